// File: doc/BRIEF.md
# Bus-Tick Countdown Timer with Programmable Divider

This block is a per-core countdown timer. A free-running bus tick feeds a power-of-two prescaler. Each divided tick lowers a current count that software loads through a small register port. When the count runs out, the timer raises a one-cycle, edge-type fixed interrupt request toward the core's priority logic. The request carries the vector held in the timer's vector-table entry. The timer can stop after one expiry or reload and run again. A pending-expiry counter records how many requests were raised since the last load.

Software reaches four registers through a 2-bit select:
- 0: initial count.
- 1: current count, read only.
- 2: divide configuration.
- 3: timer entry, which holds the vector, the mask, a delivery-status bit and the periodic bit.

Two level inputs gate delivery:
- `ctl_enable` is the controller enable.
- `sw_enable` is the software enable. While it is low, the entry's mask bit is forced set.

Top module: `bus_countdown_timer`

## Requirements
- R1: The divide code is the 3-bit value {cfg[3], cfg[1], cfg[0]}, and cfg bit 2 is ignored. The count drops once every 2^((code+1) mod 8) bus ticks. Examples: cfg 0xB divides by 1, cfg 0x0 and cfg 0x4 divide by 2, cfg 0x3 divides by 16.
- R2: A write to the initial count (select 0) loads the current count with the written value in the next cycle. It restarts the countdown and clears the pending-expiry count.
- R3: The current count (select 1) reads as the initial count minus the divided ticks elapsed since the load. In one-shot mode (entry bit 17 clear) it stays at 0 after expiry, with no further requests.
- R4: With entry bit 17 set, every expiry reloads the count from the initial count and the countdown keeps going. The interval between requests is the initial count in divided ticks.
- R5: An expiry sets `irq_req` high for one cycle and raises `pend_count` by one. `irq_vector` carries entry bits 7:0. Delivery happens only when `ctl_enable` is high, `sw_enable` is high and entry bit 16 (mask) is clear. An undelivered expiry changes neither output.
- R6: A write to the entry (select 3) keeps only bits 7:0, 12, 16 and 17. All other bits read back as 0, so writing 0xFFFFFFFF reads 0x000310FF.
- R7: While `sw_enable` is low, entry bit 16 reads as 1, including after a write that cleared it. The bit stays set after `sw_enable` returns high, and `pend_count` is held at 0 while `sw_enable` is low.
- R8: After reset:
  - the entry reads 0x00010000;
  - the initial count, current count and divide configuration read 0;
  - `irq_req` and `pend_count` are 0.
- R9: An initial count of 0 leaves the timer stopped. The current count stays 0 and no request is raised.
- R10: A write to the initial count or to the divide configuration restarts the prescaler. A full divide period must pass after the write before the next decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | One-cycle pulse per bus tick, the prescaler input |
| ctl_enable | input | 1 | Controller enable; gates request delivery |
| sw_enable | input | 1 | Software enable; when low, forces the entry mask and clears pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 initial, 1 current, 2 divide, 3 entry |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq_req | output | 1 | One-cycle fixed, edge-type interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| pend_count | output | 8 | Number of delivered expiries since the last load |

## Verification
A wrong prescaler phase or divide decode shows up at select 1 as a current count that is one step off. It becomes visible one bus tick after the first divided tick the block should have produced. A count that fails to reload or hold appears at the next expiry: either a request that should not be there or a missing one, seen on `irq_req` in the cycle after the final decrement. Errors in the mask or enable gating leave `pend_count` and the entry readback wrong from the cycle after the write or the enable change. The directed scenarios sample all of these at those points.

// File: rtl/tmr_pkg.sv
// Shared definitions for the bus-tick countdown timer.
// Assumes a 32-bit register port with a 2-bit register select.
package tmr_pkg;
    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_CUR   = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_ENTRY = 2'd3
    } reg_sel_e;

    localparam int ENT_MASK_BIT     = 16;
    localparam int ENT_PERIODIC_BIT = 17;
    localparam int ENT_STATUS_BIT   = 12;
    localparam logic [31:0] ENT_KEEP =
        32'h0000_00FF | (32'd1 << ENT_STATUS_BIT) |
        (32'd1 << ENT_MASK_BIT) | (32'd1 << ENT_PERIODIC_BIT);
    localparam logic [31:0] ENT_RESET = 32'd1 << ENT_MASK_BIT;
endpackage

// File: rtl/tmr_prescaler.sv
// Power-of-two prescaler: emits one divided tick every 2^((code+1) mod 2^CODE_W)
// bus ticks. Assumes bus_tick is a single-cycle pulse; restart clears the phase.
module tmr_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              bus_tick,
    input  logic [CODE_W-1:0] div_code,
    output logic              dtick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  limit;
    logic [CODE_W-1:0] shift;

    // Decode divide code into the terminal phase count.
    always_comb begin
        shift = div_code + 1'b1;
        limit = ~({PRE_W{1'b1}} << shift);
        dtick = bus_tick && (pre_q >= limit);
    end

    // Advance the phase counter on each bus tick, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            pre_q <= '0;
        else if (bus_tick)
            pre_q <= dtick ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/tmr_downcount.sv
// Down counter with one-shot/periodic reload. A load takes priority over a
// divided tick. Expire is a combinational pulse on the 1->0 (or reload) step.
// A count of zero is the stopped state.
module tmr_downcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dtick,
    input  logic             periodic,
    output logic [CNT_W-1:0] init_q,
    output logic [CNT_W-1:0] cur_q,
    output logic             expire
);
    // Flag the final step of a running countdown.
    always_comb expire = dtick && !load && (cur_q == CNT_W'(1));

    // Hold the initial value and step the current count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            init_q <= load_val;
            cur_q  <= load_val;
        end else if (dtick && cur_q != '0) begin
            if (expire)
                cur_q <= periodic ? init_q : '0;
            else
                cur_q <= cur_q - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_entry.sv
// Timer vector-table entry. Writes pass the keep mask; while software
// enable is low the mask bit is forced set every cycle.
module tmr_entry
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        sw_enable,
    output logic [31:0] entry_q
);
    logic [31:0] entry_nxt;

    // Form the next entry value from the write and the software enable.
    always_comb begin
        entry_nxt = wr ? (wdata & ENT_KEEP) : entry_q;
        if (!sw_enable)
            entry_nxt[ENT_MASK_BIT] = 1'b1;
    end

    // Store the entry; reset leaves it masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            entry_q <= ENT_RESET;
        else
            entry_q <= entry_nxt;
    end
endmodule

// File: rtl/bus_countdown_timer.sv
// Top of the bus-tick countdown timer: register decode, divide register,
// delivery gating, request output and pending-expiry counter.
// Assumes a single-cycle write strobe and a combinational read path.
module bus_countdown_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              ctl_enable,
    input  logic              sw_enable,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_req,
    output logic [7:0]        irq_vector,
    output logic [PEND_W-1:0] pend_count
);
    localparam int CODE_W = 3;

    reg_sel_e         sel;
    logic             wr_init, wr_div, wr_ent;
    logic [31:0]      div_q;
    logic [31:0]      entry_q;
    logic [CNT_W-1:0] init_q, cur_q;
    logic             dtick, expire, deliver;

    // Decode the register select into write strobes.
    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        wr_init = reg_wr && (sel == SEL_INIT);
        wr_div  = reg_wr && (sel == SEL_DIV);
        wr_ent  = reg_wr && (sel == SEL_ENTRY);
    end

    // Store the divide configuration (low nibble only).
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (wr_div)
            div_q <= reg_wdata & 32'h0000_000F;
    end

    tmr_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_init || wr_div),
        .bus_tick (bus_tick),
        .div_code ({div_q[3], div_q[1:0]}),
        .dtick    (dtick)
    );

    tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_init),
        .load_val (reg_wdata[CNT_W-1:0]),
        .dtick    (dtick),
        .periodic (entry_q[ENT_PERIODIC_BIT]),
        .init_q   (init_q),
        .cur_q    (cur_q),
        .expire   (expire)
    );

    tmr_entry u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ent),
        .wdata     (reg_wdata),
        .sw_enable (sw_enable),
        .entry_q   (entry_q)
    );

    // Gate an expiry into a delivered request.
    always_comb deliver = expire && ctl_enable && sw_enable && !entry_q[ENT_MASK_BIT];

    // Register the request pulse and its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_req <= deliver;
            if (deliver)
                irq_vector <= entry_q[7:0];
        end
    end

    // Count delivered expiries, saturating; cleared on load or software disable.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_init || !sw_enable)
            pend_count <= '0;
        else if (deliver && pend_count != {PEND_W{1'b1}})
            pend_count <= pend_count + 1'b1;
    end

    // Return the selected register.
    always_comb begin
        case (sel)
            SEL_INIT: reg_rdata = 32'(init_q);
            SEL_CUR:  reg_rdata = 32'(cur_q);
            SEL_DIV:  reg_rdata = div_q;
            default:  reg_rdata = entry_q;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Temporal checks on the countdown timer, attached to the top by bind.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_enable,
    input logic              ctl_enable,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq_req,
    input logic [7:0]        irq_vector,
    input logic [PEND_W-1:0] pend_count,
    input logic [CNT_W-1:0]  init_q,
    input logic [CNT_W-1:0]  cur_q,
    input logic [31:0]       entry_q
);
    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(ctl_enable && sw_enable && !entry_q[ENT_MASK_BIT]));

    // R5
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vector == $past(entry_q[7:0]));

    // R7
    sw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |=> entry_q[ENT_MASK_BIT]);

    // R2
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_INIT) |=>
            (cur_q == $past(reg_wdata[CNT_W-1:0]) && pend_count == '0));

    // R3
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == '0 && !(reg_wr && reg_addr == SEL_INIT)) |=> cur_q == '0);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= init_q);
endmodule

bind bus_countdown_timer tmr_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_enable  (sw_enable),
    .ctl_enable (ctl_enable),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .pend_count (pend_count),
    .init_q     (init_q),
    .cur_q      (cur_q),
    .entry_q    (entry_q)
);

// File: tb/bus_countdown_timer_test.sv
// Directed bench: one task per scenario, each checking its own results.
module bus_countdown_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic        ctl_enable = 1'b1;
    logic        sw_enable = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic [7:0]  pend_count;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    logic [7:0] last_vec = '0;

    bus_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .ctl_enable(ctl_enable),
        .sw_enable(sw_enable), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_vector(irq_vector), .pend_count(pend_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count request pulses and remember the vector.
    always @(posedge clk) begin
        if (rst_n && irq_req) begin
            irq_seen = irq_seen + 1;
            last_vec = irq_vector;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bus_tick = 1'b1;
            @(negedge clk); bus_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R8 init", v, 32'h0);
        rd(2'd1, v); check("R8 cur", v, 32'h0);
        rd(2'd2, v); check("R8 div", v, 32'h0);
        rd(2'd3, v); check("R8 entry", v, 32'h0001_0000);
        check("R8 irq", {31'h0, irq_req}, 32'h0);
        check("R8 pend", {24'h0, pend_count}, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v; int base;
        wr(2'd2, 32'hB);
        wr(2'd3, 32'h21);
        base = irq_seen;
        wr(2'd0, 32'd5);
        ticks(2); rd(2'd1, v); check("R3 partial count", v, 32'd3);
        ticks(3); idle(2);
        rd(2'd1, v); check("R3 expired count", v, 32'd0);
        check("R5 one request", irq_seen - base, 32'd1);
        check("R5 vector", {24'h0, last_vec}, 32'h21);
        check("R5 pending", {24'h0, pend_count}, 32'd1);
        ticks(4); idle(2);
        rd(2'd1, v); check("R3 holds at zero", v, 32'd0);
        check("R3 no re-fire", irq_seen - base, 32'd1);
    endtask

    task automatic t_periodic();
        logic [31:0] v; int base;
        wr(2'd3, (32'd1 << 17) | 32'h40);
        base = irq_seen;
        wr(2'd0, 32'd3);
        ticks(3); idle(2);
        rd(2'd1, v); check("R4 reloaded", v, 32'd3);
        check("R4 first request", irq_seen - base, 32'd1);
        ticks(1); rd(2'd1, v); check("R4 keeps running", v, 32'd2);
        ticks(2); idle(2);
        check("R4 second request", irq_seen - base, 32'd2);
        check("R4 vector", {24'h0, last_vec}, 32'h40);
        check("R5 pending two", {24'h0, pend_count}, 32'd2);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(2'd0, 32'd7);
        rd(2'd1, v); check("R2 reload value", v, 32'd7);
        check("R2 pending cleared", {24'h0, pend_count}, 32'd0);
        ticks(1); rd(2'd1, v); check("R2 counting", v, 32'd6);
    endtask

    task automatic t_divide();
        logic [31:0] v;
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h0); wr(2'd0, 32'd4);
        ticks(3); rd(2'd1, v); check("R1 code000 div2", v, 32'd3);
        wr(2'd2, 32'h4); wr(2'd0, 32'd4);
        ticks(1); rd(2'd1, v); check("R1 bit2 ignored a", v, 32'd4);
        ticks(1); rd(2'd1, v); check("R1 bit2 ignored b", v, 32'd3);
        wr(2'd2, 32'h3); wr(2'd0, 32'd2);
        ticks(15); rd(2'd1, v); check("R1 div16 before", v, 32'd2);
        ticks(1); rd(2'd1, v); check("R1 div16 edge", v, 32'd1);
        rd(2'd2, v); check("R1 div readback", v, 32'h3);
    endtask

    task automatic t_prescale_restart();
        logic [31:0] v;
        wr(2'd2, 32'h0); wr(2'd0, 32'd10);
        ticks(1); wr(2'd2, 32'h0);
        ticks(1); rd(2'd1, v); check("R10 cfg write restarts", v, 32'd10);
        ticks(1); rd(2'd1, v); check("R10 full period", v, 32'd9);
        ticks(1); wr(2'd0, 32'd10);
        ticks(1); rd(2'd1, v); check("R10 init write restarts", v, 32'd10);
    endtask

    task automatic t_gating();
        logic [31:0] v; int base;
        wr(2'd2, 32'hB);
        wr(2'd3, 32'h0001_0022);
        base = irq_seen;
        wr(2'd0, 32'd2); ticks(2); idle(2);
        rd(2'd1, v); check("R5 masked expiry count", v, 32'd0);
        check("R5 masked no request", irq_seen - base, 32'd0);
        check("R5 masked no pending", {24'h0, pend_count}, 32'd0);
        wr(2'd3, 32'h22);
        ctl_enable = 1'b0;
        wr(2'd0, 32'd2); ticks(2); idle(2);
        check("R5 ctl disabled no request", irq_seen - base, 32'd0);
        check("R5 ctl disabled no pending", {24'h0, pend_count}, 32'd0);
        ctl_enable = 1'b1;
    endtask

    task automatic t_wmask();
        logic [31:0] v;
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check("R6 write mask", v, 32'h0003_10FF);
        wr(2'd3, 32'h0);
    endtask

    task automatic t_swdis();
        logic [31:0] v; int base;
        wr(2'd2, 32'hB);
        wr(2'd3, (32'd1 << 17) | 32'h23);
        wr(2'd0, 32'd2); ticks(2); idle(2);
        check("R5 pending before disable", {24'h0, pend_count}, 32'd1);
        sw_enable = 1'b0;
        idle(2);
        check("R7 pending cleared", {24'h0, pend_count}, 32'd0);
        rd(2'd3, v); check("R7 mask set on disable", v, 32'h0003_0023);
        wr(2'd3, 32'h24);
        rd(2'd3, v); check("R7 write forced masked", v, 32'h0001_0024);
        base = irq_seen;
        wr(2'd0, 32'd2); ticks(2); idle(2);
        check("R7 no request while disabled", irq_seen - base, 32'd0);
        sw_enable = 1'b1;
        idle(1);
        rd(2'd3, v); check("R7 mask stays after enable", v, 32'h0001_0024);
    endtask

    task automatic t_zero();
        logic [31:0] v; int base;
        wr(2'd3, 32'h25);
        base = irq_seen;
        wr(2'd0, 32'd0); ticks(5); idle(2);
        rd(2'd1, v); check("R9 stays zero", v, 32'd0);
        check("R9 no request", irq_seen - base, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_oneshot();
        t_periodic();
        t_restart();
        t_divide();
        t_prescale_restart();
        t_gating();
        t_wmask();
        t_swdis();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule